// File: doc/BRIEF.md
# Scroll-match trigger channel monitor

This block sits beside a video control register that holds a 3-bit vertical scroll field and a display-enable bit. It watches the CPU writes to that register and the low bits of the raster line counter. It raises a match flag whenever the stored scroll value equals the raster low bits. When a write turns a non-matching scroll value into a matching one, the block reports a mid-line scroll trigger. The trigger carries a channel number: the XOR of the scroll value held before the write and the value written. A write that sets the display-enable bit onto a matching line is a second kind of trigger, and it is reported on its own output.

Every scroll trigger is tallied in a grid of saturating counters. The grid has one row for each raster low-bit value and one column for each channel from 1 to 7. A combinational read port returns the selected cell. A set of per-channel "seen" flags marks which channels have fired. A clear input resets these flags and leaves the counters alone. Software can use the block to check that a pair of writes (the target value XOR a chosen channel, then the target value) lands on the chosen channel.

Top module: `scroll_chan_mon`

## Requirements
- R1: `match` is high exactly when each of the three stored scroll bits equals the matching bit of `raster_line[2:0]`. It follows a change of either side in the same cycle.
- R2: A write (`wr_en`) whose scroll field `wr_data[2:0]` equals `raster_line[2:0]`, while the stored scroll value does not, raises `trig` for exactly the one clock cycle after the write edge.
- R3: In the cycle `trig` is high, `trig_chan` equals the old stored scroll value XOR the written scroll value. This is always in 1..7. When `trig` is low, `trig_chan` is 0.
- R4: There is no `trig` pulse when a write leaves the match state unchanged (matching to matching, or non-matching to non-matching), or when the raster value changes without a write.
- R5: A write that sets `wr_data[4]` (display enable) while the stored enable is 0, with a written scroll field equal to `raster_line[2:0]`, raises `trig_den` for one cycle. This is independent of `trig`: both can fire on the same write. Enable triggers are not counted in the grid.
- R6: Two back-to-back writes, X XOR k and then X, with X equal to the raster low bits and k in 1..7, give no trigger on the first write and a trigger with `trig_chan` = k on the second.
- R7: Each scroll trigger increments the grid cell at row `raster_line[2:0]`, column `trig_chan`. `rd_data` returns the cell at row `rd_row`, column `rd_col`, in the same cycle. `rd_col` = 0 reads as 0.
- R8: Each cell is a `CNT_W`-bit counter (16 by default) that stops at all ones.
- R9: `seen[k-1]` is set by a scroll trigger on channel k. `clr_seen` clears all flags and no counter. A trigger in the same cycle as `clr_seen` still sets its flag.
- R10: A synchronous `rst` clears the stored scroll value and enable to 0, all counters, all flags and both trigger outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| raster_line | input | RASTER_W | Current raster line, sampled every clock |
| wr_en | input | 1 | CPU write strobe to the control register |
| wr_data | input | REG_W | Written byte: scroll field at bits 2:0, display enable at bit 4 |
| clr_seen | input | 1 | Clears the per-channel seen flags |
| rd_row | input | 3 | Grid read row (raster low bits) |
| rd_col | input | 3 | Grid read column (channel 1..7) |
| match | output | 1 | Stored scroll equals raster low bits |
| trig | output | 1 | One-cycle scroll trigger pulse |
| trig_chan | output | 3 | Channel of the current trigger |
| trig_den | output | 1 | One-cycle display-enable trigger pulse |
| seen | output | 7 | Bit k-1 set once channel k has fired |
| rd_data | output | CNT_W | Selected grid counter |

## Verification
Two functions can fall in the same cycle. A trigger can set a seen flag in the cycle that `clr_seen` wipes all flags. A single write can also raise both the scroll trigger and the enable trigger. The bench asserts `clr_seen` together with a triggering write and expects only the new channel's flag to remain, with the counters unchanged. A separate write flips the scroll field into a match and sets the enable bit at once, and both pulses must appear in the same cycle.

// File: rtl/scm_pkg.sv
package scm_pkg;
   localparam int SCROLL_W = 3;
   localparam int NUM_ROWS = 1 << SCROLL_W;
   localparam int NUM_CH   = NUM_ROWS - 1;

   typedef logic [SCROLL_W-1:0] scroll_t;

   typedef struct packed {
      logic    hit;
      logic    den_hit;
      scroll_t chan;
      scroll_t row;
   } scm_evt_t;
endpackage

// File: rtl/scm_match_cmp.sv
module scm_match_cmp #(
   parameter int W = 3
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic         eq
);
   logic [W-1:0] diff;

   generate
      for (genvar i = 0; i < W; i++) begin : g_bit
         assign diff[i] = a[i] ^ b[i];
      end
   endgenerate

   // all bits equal: NOR of the per-bit differences
   assign eq = ~|diff;
endmodule

// File: rtl/scm_trig_det.sv
module scm_trig_det
   import scm_pkg::*;
(
   input  logic     clk,
   input  logic     rst,
   input  scroll_t  raster_lo,
   input  logic     wr_en,
   input  scroll_t  wr_scroll,
   input  logic     wr_den,
   output logic     cur_match,
   output scm_evt_t evt,
   output logic     trig,
   output logic     trig_den,
   output scroll_t  trig_chan
);
   scroll_t scroll_q;
   logic    den_q;
   logic    new_match;

   scm_match_cmp #(.W(SCROLL_W)) u_old (.a(scroll_q),  .b(raster_lo), .eq(cur_match));
   scm_match_cmp #(.W(SCROLL_W)) u_new (.a(wr_scroll), .b(raster_lo), .eq(new_match));

   always_comb begin
      evt.hit     = wr_en & ~cur_match & new_match;
      evt.den_hit = wr_en & ~den_q & wr_den & new_match;
      evt.chan    = scroll_q ^ wr_scroll;
      evt.row     = raster_lo;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         scroll_q  <= '0;
         den_q     <= 1'b0;
         trig      <= 1'b0;
         trig_den  <= 1'b0;
         trig_chan <= '0;
      end else begin
         if (wr_en) begin
            scroll_q <= wr_scroll;
            den_q    <= wr_den;
         end
         trig      <= evt.hit;
         trig_den  <= evt.den_hit;
         trig_chan <= evt.hit ? evt.chan : '0;
      end
   end
endmodule

// File: rtl/scm_hit_grid.sv
module scm_hit_grid
   import scm_pkg::*;
#(
   parameter int CNT_W    = 16,
   parameter bit SATURATE = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  scm_evt_t          evt,
   input  logic              clr_seen,
   input  scroll_t           rd_row,
   input  scroll_t           rd_col,
   output logic [NUM_CH-1:0] seen,
   output logic [CNT_W-1:0]  rd_data
);
   localparam int CELLS = NUM_ROWS * NUM_CH;

   logic [CELLS*CNT_W-1:0] flat;
   logic [NUM_CH-1:0]      set_vec;

   generate
      for (genvar r = 0; r < NUM_ROWS; r++) begin : g_row
         for (genvar c = 0; c < NUM_CH; c++) begin : g_col
            logic [CNT_W-1:0] cnt_q;
            logic             bump;
            assign bump = evt.hit && (evt.row == scroll_t'(r)) && (evt.chan == scroll_t'(c + 1));
            if (SATURATE) begin : g_sat
               always_ff @(posedge clk) begin
                  if (rst)                   cnt_q <= '0;
                  else if (bump && ~&cnt_q)  cnt_q <= cnt_q + 1'b1;
               end
            end else begin : g_wrap
               always_ff @(posedge clk) begin
                  if (rst)       cnt_q <= '0;
                  else if (bump) cnt_q <= cnt_q + 1'b1;
               end
            end
            assign flat[(r*NUM_CH + c)*CNT_W +: CNT_W] = cnt_q;
         end
      end
      for (genvar k = 0; k < NUM_CH; k++) begin : g_set
         assign set_vec[k] = evt.hit && (evt.chan == scroll_t'(k + 1));
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) seen <= '0;
      else     seen <= (clr_seen ? '0 : seen) | set_vec;
   end

   always_comb begin
      int idx;
      idx     = int'(rd_row) * NUM_CH + int'(rd_col) - 1;
      rd_data = '0;
      if (rd_col != '0) rd_data = flat[idx*CNT_W +: CNT_W];
   end
endmodule

// File: rtl/scroll_chan_mon.sv
module scroll_chan_mon
   import scm_pkg::*;
#(
   parameter int RASTER_W   = 9,
   parameter int REG_W      = 8,
   parameter int SCROLL_LSB = 0,
   parameter int DEN_BIT    = 4,
   parameter int CNT_W      = 16,
   parameter bit SATURATE   = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic [RASTER_W-1:0]  raster_line,
   input  logic                 wr_en,
   input  logic [REG_W-1:0]     wr_data,
   input  logic                 clr_seen,
   input  logic [SCROLL_W-1:0]  rd_row,
   input  logic [SCROLL_W-1:0]  rd_col,
   output logic                 match,
   output logic                 trig,
   output logic [SCROLL_W-1:0]  trig_chan,
   output logic                 trig_den,
   output logic [NUM_CH-1:0]    seen,
   output logic [CNT_W-1:0]     rd_data
);
   localparam int SCROLL_MSB = SCROLL_LSB + SCROLL_W - 1;

   generate
      if (RASTER_W < SCROLL_W || SCROLL_MSB >= REG_W || DEN_BIT >= REG_W || CNT_W < 1) begin : g_bad_width
         $error("scroll_chan_mon: field widths do not fit");
      end
      if (DEN_BIT >= SCROLL_LSB && DEN_BIT <= SCROLL_MSB) begin : g_bad_den
         $error("scroll_chan_mon: enable bit overlaps scroll field");
      end
   endgenerate

   scm_evt_t evt;
   scroll_t  raster_lo;

   assign raster_lo = raster_line[SCROLL_W-1:0];

   scm_trig_det u_det (
      .clk       (clk),
      .rst       (rst),
      .raster_lo (raster_lo),
      .wr_en     (wr_en),
      .wr_scroll (wr_data[SCROLL_MSB:SCROLL_LSB]),
      .wr_den    (wr_data[DEN_BIT]),
      .cur_match (match),
      .evt       (evt),
      .trig      (trig),
      .trig_den  (trig_den),
      .trig_chan (trig_chan)
   );

   scm_hit_grid #(.CNT_W(CNT_W), .SATURATE(SATURATE)) u_grid (
      .clk      (clk),
      .rst      (rst),
      .evt      (evt),
      .clr_seen (clr_seen),
      .rd_row   (rd_row),
      .rd_col   (rd_col),
      .seen     (seen),
      .rd_data  (rd_data)
   );
endmodule

// File: rtl/scroll_chan_mon_chk.sv
module scroll_chan_mon_chk #(
   parameter int RASTER_W   = 9,
   parameter int REG_W      = 8,
   parameter int SCROLL_LSB = 0,
   parameter int DEN_BIT    = 4
) (
   input logic                clk,
   input logic                rst,
   input logic [RASTER_W-1:0] raster_line,
   input logic                wr_en,
   input logic [REG_W-1:0]    wr_data,
   input logic                clr_seen,
   input logic                match,
   input logic                trig,
   input logic [2:0]          trig_chan,
   input logic                trig_den,
   input logic [6:0]          seen
);
   assert_trig_from_write_R2: assert property (@(posedge clk) disable iff (rst)
      trig |-> ($past(wr_en) && ($past(wr_data[SCROLL_LSB +: 3]) == $past(raster_line[2:0]))));

   assert_chan_range_R3: assert property (@(posedge clk) disable iff (rst)
      trig |-> (trig_chan != 3'd0));

   assert_no_trig_when_matched_R4: assert property (@(posedge clk) disable iff (rst)
      (wr_en && match) |=> !trig);

   assert_den_from_write_R5: assert property (@(posedge clk) disable iff (rst)
      trig_den |-> ($past(wr_en) && $past(wr_data[DEN_BIT]) &&
                    ($past(wr_data[SCROLL_LSB +: 3]) == $past(raster_line[2:0]))));

   assert_seen_follows_trig_R9: assert property (@(posedge clk) disable iff (rst)
      trig |-> seen[3'(trig_chan - 3'd1)]);

   assert_seen_only_cleared_R9: assert property (@(posedge clk) disable iff (rst)
      (|($past(seen) & ~seen)) |-> $past(clr_seen));

   assert_reset_state_R10: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (!trig && !trig_den && (seen == 7'd0)));
endmodule

bind scroll_chan_mon scroll_chan_mon_chk #(
   .RASTER_W   (RASTER_W),
   .REG_W      (REG_W),
   .SCROLL_LSB (SCROLL_LSB),
   .DEN_BIT    (DEN_BIT)
) u_chk (
   .clk         (clk),
   .rst         (rst),
   .raster_line (raster_line),
   .wr_en       (wr_en),
   .wr_data     (wr_data),
   .clr_seen    (clr_seen),
   .match       (match),
   .trig        (trig),
   .trig_chan   (trig_chan),
   .trig_den    (trig_den),
   .seen        (seen)
);

// File: tb/scroll_chan_mon_test.sv
module scroll_chan_mon_test;
   localparam int CW = 4;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic [8:0]    raster_line = '0;
   logic          wr_en = 1'b0;
   logic [7:0]    wr_data = '0;
   logic          clr_seen = 1'b0;
   logic [2:0]    rd_row = '0;
   logic [2:0]    rd_col = '0;
   logic          match, trig, trig_den;
   logic [2:0]    trig_chan;
   logic [6:0]    seen;
   logic [CW-1:0] rd_data;

   int errors = 0;
   int checks = 0;
   int exp_cnt [8][8];

   always #5 clk = ~clk;

   scroll_chan_mon #(.CNT_W(CW)) uut (
      .clk(clk), .rst(rst), .raster_line(raster_line), .wr_en(wr_en), .wr_data(wr_data),
      .clr_seen(clr_seen), .rd_row(rd_row), .rd_col(rd_col), .match(match), .trig(trig),
      .trig_chan(trig_chan), .trig_den(trig_den), .seen(seen), .rd_data(rd_data));

   // {raster[2:0], data[7:0], exp trig, exp chan[2:0], exp den trig}
   localparam int NV = 14;
   localparam logic [15:0] VEC [NV] = '{
      {3'd2, 8'h05, 1'b0, 3'd0, 1'b0},
      {3'd2, 8'h02, 1'b1, 3'd7, 1'b0},
      {3'd2, 8'h02, 1'b0, 3'd0, 1'b0},
      {3'd6, 8'h07, 1'b0, 3'd0, 1'b0},
      {3'd6, 8'h06, 1'b1, 3'd1, 1'b0},
      {3'd6, 8'h16, 1'b0, 3'd0, 1'b1},
      {3'd6, 8'h16, 1'b0, 3'd0, 1'b0},
      {3'd1, 8'h04, 1'b0, 3'd0, 1'b0},
      {3'd1, 8'h11, 1'b1, 3'd5, 1'b1},
      {3'd0, 8'h03, 1'b0, 3'd0, 1'b0},
      {3'd0, 8'h00, 1'b1, 3'd3, 1'b0},
      {3'd7, 8'h07, 1'b1, 3'd7, 1'b0},
      {3'd7, 8'h11, 1'b0, 3'd0, 1'b0},
      {3'd4, 8'h04, 1'b1, 3'd5, 1'b0}
   };

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] r, input logic [7:0] d);
      raster_line = {6'd0, r};
      wr_data     = d;
      wr_en       = 1'b1;
      @(posedge clk);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input int r, input int c, output int v);
      rd_row = 3'(r);
      rd_col = 3'(c);
      #1 v = int'(rd_data);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      int v;
      for (int r = 0; r < 8; r++) for (int c = 0; c < 8; c++) exp_cnt[r][c] = 0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      // R10 reset state
      chk("R10 trig after reset", int'(trig), 0);
      chk("R10 seen after reset", int'(seen), 0);
      chk("R1 match scroll0 raster0", int'(match), 1);

      // table walk: R1 R2 R3 R4 R5
      for (int i = 0; i < NV; i++) begin
         logic [2:0] vr;
         logic [7:0] vd;
         logic       et, ed;
         logic [2:0] ec;
         {vr, vd, et, ec, ed} = VEC[i];
         wr(vr, vd);
         chk($sformatf("R2 trig vec%0d", i), int'(trig), int'(et));
         chk($sformatf("R3 chan vec%0d", i), int'(trig_chan), int'(ec));
         chk($sformatf("R5 den trig vec%0d", i), int'(trig_den), int'(ed));
         chk($sformatf("R1 match vec%0d", i), int'(match), int'(vd[2:0] == vr));
         if (et) exp_cnt[vr][ec]++;
      end
      chk("R9 seen after table", int'(seen), 'h55);

      // R6 back-to-back pair, X = 3, channel 6
      wr(3'd3, 8'h05);
      chk("R6 first write no trig", int'(trig), 0);
      wr(3'd3, 8'h03);
      chk("R6 second write trig", int'(trig), 1);
      chk("R6 second write chan", int'(trig_chan), 6);
      exp_cnt[3][6]++;
      @(negedge clk);
      chk("R2 pulse lasts one cycle", int'(trig), 0);
      chk("R3 chan idle zero", int'(trig_chan), 0);

      // R4 raster moving into match without a write
      raster_line = 9'd2;
      @(negedge clk);
      chk("R1 match drops with raster", int'(match), 0);
      raster_line = 9'd3;
      #1 chk("R1 match rises with raster", int'(match), 1);
      @(negedge clk);
      chk("R4 no trig on raster move", int'(trig), 0);

      // R9 clear coinciding with a trigger (channel 3^1 = 2, row 1)
      clr_seen = 1'b1;
      wr(3'd1, 8'h01);
      clr_seen = 1'b0;
      exp_cnt[1][2]++;
      chk("R9 clear with trigger keeps new flag", int'(seen), 'h02);
      clr_seen = 1'b1;
      @(negedge clk);
      clr_seen = 1'b0;
      chk("R9 clear alone", int'(seen), 0);
      rd(1, 2, v);
      chk("R9 clear keeps counter", v, exp_cnt[1][2]);

      // R8 saturation on row 0 channel 1
      for (int n = 0; n < 20; n++) begin
         wr(3'd0, 8'h01);
         wr(3'd0, 8'h00);
      end
      exp_cnt[0][1] += 20;
      if (exp_cnt[0][1] > (1 << CW) - 1) exp_cnt[0][1] = (1 << CW) - 1;
      rd(0, 1, v);
      chk("R8 saturated counter", v, (1 << CW) - 1);

      // R7 full grid read, R5 den triggers not counted
      for (int r = 0; r < 8; r++)
         for (int c = 1; c < 8; c++) begin
            rd(r, c, v);
            chk($sformatf("R7 cell row%0d col%0d", r, c), v, exp_cnt[r][c]);
         end
      rd(2, 0, v);
      chk("R7 column zero reads zero", v, 0);

      // R10 reset clears everything
      @(negedge clk);
      rst = 1'b1;
      raster_line = 9'd0;
      repeat (2) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      chk("R10 seen cleared", int'(seen), 0);
      chk("R10 trig cleared", int'(trig), 0);
      chk("R10 scroll cleared so match", int'(match), 1);
      rd(0, 1, v);
      chk("R10 counter cleared", v, 0);
      rd(2, 7, v);
      chk("R10 counter row2 cleared", v, 0);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule